// File: doc/BRIEF.md
# Prefix-coded instruction decoder with memory-step sequencer

This block sits between instruction fetch and a single-port RAM in a small 16-bit, word-addressed processor whose eight general registers are not a separate file. They are an eight-word slice of the same memory that holds code and data. An accepted instruction word is split into its class, register fields and extended immediate. The block then emits, one per cycle, the ordered accesses that the instruction needs on the shared RAM: register-slot reads, the main-memory or external-space access, the register write-back, and the jump step. An ALU, a branch-condition unit and the address adder, all outside this block, consume the decoded fields and the step stream.

Both data-carrying edges are valid/ready. The instruction is taken when `in_valid` and `in_ready` are both high. `in_ready` is high when no instruction is held, or in the same cycle that the held instruction finishes: its final step handshakes, or it is an illegal encoding. This lets a new word enter with no bubble cycle, and it means `in_ready` depends combinationally on `step_ready`. A step is transferred when `step_valid` and `step_ready` are both high. While `step_ready` is low, the offered step does not change. Decoded fields stay valid, and stay constant, from the cycle after acceptance until the instruction completes.

Top module: `pfx_insn_decoder`

## Requirements
- R1: While `dec_valid` is high, `dec_opcode` equals instruction bits [15:11]. `dec_class` is 4 (control) when bit 15 is 1, 3 (immediate) for 01xxx, 2 (load/store) for 001xx, 1 (shift) for 0001x, and 0 (ALU) for 0000x.
- R2: `dec_rd` carries bits [10:8], `dec_ra` carries bits [7:5] and `dec_rb` carries bits [4:2] of the held instruction, for every class.
- R3: `dec_imm` is one of the following. For control: bits [10:0] sign-extended to 16 bits. For immediate: bits [7:0] sign-extended. For load/store: bits [4:0] zero-extended. For shift: bits [4:1] zero-extended. For ALU: zero.
- R4: An ALU instruction emits a register read of rb, then a register read of ra, then a register write of rd. Step codes are 1 = register read, 2 = register write, 3 = memory read, 4 = memory write, 5 = external read, 6 = external write, 7 = jump.
- R5: A shift instruction emits a register read of ra, then a register write of rd.
- R6: In load/store, opcode bit 11 selects store and bit 12 selects the external space. A load emits: read ra, then a memory or external read, then a write of rd. A store emits: read ra, then read rd, then a memory or external write. A store never writes a register slot.
- R7: In the immediate class, opcodes behave as follows. 0100x emits read rd, then write rd. 0101x emits write rd. 01100 emits memory read, then write rd. 01101 emits read rd, then memory write. 01110 emits write rd, then jump. 01111 emits read rd, then jump.
- R8: Every legal control-class instruction emits exactly one jump step.
- R9: A register step carries address {`win_base`[15:3], slot}, and the low three bits of `win_base` are ignored. Every other step carries address 0.
- R10: ALU type 11 (in either group) and opcode 10001 raise `dec_illegal` and emit no step. The instruction is retired one cycle after acceptance.
- R11: `step_last` marks the final step. A step offered with `step_ready` low is held unchanged. `in_ready` follows the completion rule given above.
- R12: During and right after reset, no instruction is held: `dec_valid` and `step_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_base | input | AW | Register window base; low 3 bits ignored |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Instruction word taken this cycle if valid |
| in_instr | input | 16 | Instruction word |
| dec_valid | output | 1 | An instruction is held and its fields are valid |
| dec_class | output | 3 | Instruction class code |
| dec_opcode | output | 5 | Prefix opcode, bits [15:11] |
| dec_rd | output | 3 | Destination / data register slot |
| dec_ra | output | 3 | Operand A / address register slot |
| dec_rb | output | 3 | Operand B register slot |
| dec_imm | output | 16 | Extended immediate or offset |
| dec_illegal | output | 1 | Held instruction is an unassigned encoding |
| step_valid | output | 1 | A RAM step is offered |
| step_ready | input | 1 | The RAM takes the offered step |
| step_op | output | 3 | Step code |
| step_addr | output | AW | Physical address for register steps, else 0 |
| step_last | output | 1 | Offered step is the instruction's final one |

## Verification
The bench first walks one hand-picked encoding for each of the 32 prefix opcodes that matters. This separates neighbouring classes that differ in a single prefix bit, such as load against store, internal against external space, and the two illegal codes against their legal neighbours. Random words then exercise the sign- and zero-extension boundaries with arbitrary field contents. `step_ready` is driven low at random, so that step holding and the same-cycle handoff of `in_ready` are both hit. The window base, including its ignored low bits, changes while instructions are in flight. This separates address formation from slot selection.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

  localparam int IW        = 16;
  localparam int NREG      = 8;
  localparam int SLOTW     = $clog2(NREG);
  localparam int MAX_STEPS = 3;
  localparam int IDXW      = $clog2(MAX_STEPS);
  localparam int CNTW      = $clog2(MAX_STEPS + 1);

  typedef enum logic [2:0] {
    CL_ALU   = 3'd0,
    CL_SHIFT = 3'd1,
    CL_MEM   = 3'd2,
    CL_IMM   = 3'd3,
    CL_CTRL  = 3'd4
  } iclass_e;

  typedef enum logic [2:0] {
    SP_NONE   = 3'd0,
    SP_REG_RD = 3'd1,
    SP_REG_WR = 3'd2,
    SP_MEM_RD = 3'd3,
    SP_MEM_WR = 3'd4,
    SP_EXT_RD = 3'd5,
    SP_EXT_WR = 3'd6,
    SP_JUMP   = 3'd7
  } step_op_e;

  typedef struct packed {
    step_op_e         op;
    logic [SLOTW-1:0] slot;
  } step_t;

endpackage

// File: rtl/pfx_field_dec.sv
module pfx_field_dec
  import pfx_dec_pkg::*;
(
  input  logic [IW-1:0]    instr,
  output iclass_e          cls,
  output logic [4:0]       opcode,
  output logic [SLOTW-1:0] rd,
  output logic [SLOTW-1:0] ra,
  output logic [SLOTW-1:0] rb,
  output logic [IW-1:0]    imm,
  output logic             illegal
);

  localparam logic [4:0] OPC_UNASSIGNED_JUMP = 5'b10001;

  assign opcode = instr[IW-1 -: 5];
  assign rd     = instr[10:8];
  assign ra     = instr[7:5];
  assign rb     = instr[4:2];

  // Prefix code: first set bit from the top picks the class.
  always_comb begin
    if (instr[15])      cls = CL_CTRL;
    else if (instr[14]) cls = CL_IMM;
    else if (instr[13]) cls = CL_MEM;
    else if (instr[12]) cls = CL_SHIFT;
    else                cls = CL_ALU;
  end

  always_comb begin
    unique case (cls)
      CL_CTRL:  imm = {{(IW-11){instr[10]}}, instr[10:0]};
      CL_IMM:   imm = {{(IW-8){instr[7]}}, instr[7:0]};
      CL_MEM:   imm = {{(IW-5){1'b0}}, instr[4:0]};
      CL_SHIFT: imm = {{(IW-4){1'b0}}, instr[4:1]};
      default:  imm = '0;
    endcase
  end

  assign illegal = ((cls == CL_ALU) && (instr[1:0] == 2'b11)) ||
                   (opcode == OPC_UNASSIGNED_JUMP);

endmodule

// File: rtl/pfx_step_plan.sv
module pfx_step_plan
  import pfx_dec_pkg::*;
(
  input  logic [IW-1:0]    instr,
  input  iclass_e          cls,
  input  logic [SLOTW-1:0] rd,
  input  logic [SLOTW-1:0] ra,
  input  logic [SLOTW-1:0] rb,
  input  logic             illegal,
  output logic [CNTW-1:0]  count,
  output step_t            steps [MAX_STEPS]
);

  logic is_store;
  logic is_ext;
  logic unused_plan;

  assign is_store    = instr[11];
  assign is_ext      = instr[12];
  assign unused_plan = ^{instr[IW-1:14], instr[10:0]};

  always_comb begin
    for (int i = 0; i < MAX_STEPS; i++) steps[i] = '{op: SP_NONE, slot: '0};
    count = '0;
    unique case (cls)
      CL_ALU: begin
        steps[0] = '{op: SP_REG_RD, slot: rb};
        steps[1] = '{op: SP_REG_RD, slot: ra};
        steps[2] = '{op: SP_REG_WR, slot: rd};
        count    = CNTW'(3);
      end
      CL_SHIFT: begin
        steps[0] = '{op: SP_REG_RD, slot: ra};
        steps[1] = '{op: SP_REG_WR, slot: rd};
        count    = CNTW'(2);
      end
      CL_MEM: begin
        steps[0] = '{op: SP_REG_RD, slot: ra};
        if (is_store) begin
          steps[1] = '{op: SP_REG_RD, slot: rd};
          steps[2] = '{op: (is_ext ? SP_EXT_WR : SP_MEM_WR), slot: '0};
        end else begin
          steps[1] = '{op: (is_ext ? SP_EXT_RD : SP_MEM_RD), slot: '0};
          steps[2] = '{op: SP_REG_WR, slot: rd};
        end
        count = CNTW'(3);
      end
      CL_IMM: begin
        unique casez (instr[13:11])
          3'b00?: begin
            steps[0] = '{op: SP_REG_RD, slot: rd};
            steps[1] = '{op: SP_REG_WR, slot: rd};
            count    = CNTW'(2);
          end
          3'b01?: begin
            steps[0] = '{op: SP_REG_WR, slot: rd};
            count    = CNTW'(1);
          end
          3'b100: begin
            steps[0] = '{op: SP_MEM_RD, slot: '0};
            steps[1] = '{op: SP_REG_WR, slot: rd};
            count    = CNTW'(2);
          end
          3'b101: begin
            steps[0] = '{op: SP_REG_RD, slot: rd};
            steps[1] = '{op: SP_MEM_WR, slot: '0};
            count    = CNTW'(2);
          end
          3'b110: begin
            steps[0] = '{op: SP_REG_WR, slot: rd};
            steps[1] = '{op: SP_JUMP, slot: '0};
            count    = CNTW'(2);
          end
          default: begin
            steps[0] = '{op: SP_REG_RD, slot: rd};
            steps[1] = '{op: SP_JUMP, slot: '0};
            count    = CNTW'(2);
          end
        endcase
      end
      default: begin
        steps[0] = '{op: SP_JUMP, slot: '0};
        count    = CNTW'(1);
      end
    endcase
    if (illegal) count = '0;
  end

endmodule

// File: rtl/pfx_step_seq.sv
module pfx_step_seq
  import pfx_dec_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   win_base,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IW-1:0]   in_instr,
  input  logic [CNTW-1:0] count,
  input  step_t           steps [MAX_STEPS],
  output logic            held,
  output logic [IW-1:0]   instr_q,
  output logic            step_valid,
  input  logic            step_ready,
  output logic [2:0]      step_op,
  output logic [AW-1:0]   step_addr,
  output logic            step_last
);

  logic            busy_q;
  logic [IDXW-1:0] idx_q;
  step_t           cur;
  logic            fire;
  logic            done;
  logic            accept;
  logic            is_reg_step;
  logic            unused_base;

  assign unused_base = ^win_base[SLOTW-1:0];

  always_comb begin
    cur = '{op: SP_NONE, slot: '0};
    for (int i = 0; i < MAX_STEPS; i++)
      if (idx_q == IDXW'(i)) cur = steps[i];
  end

  assign step_valid  = busy_q && (CNTW'(idx_q) < count);
  assign step_last   = (CNTW'(idx_q) + CNTW'(1)) == count;
  assign fire        = step_valid && step_ready;
  assign done        = busy_q && ((count == '0) || (fire && step_last));
  assign in_ready    = !busy_q || done;
  assign accept      = in_valid && in_ready;

  assign is_reg_step = (cur.op == SP_REG_RD) || (cur.op == SP_REG_WR);
  assign step_op     = cur.op;
  assign step_addr   = is_reg_step ? {win_base[AW-1:SLOTW], cur.slot} : '0;

  assign held        = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      instr_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      instr_q <= in_instr;
    end else if (done) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else if (fire) begin
      idx_q   <= idx_q + IDXW'(1);
    end
  end

endmodule

// File: rtl/pfx_insn_decoder.sv
module pfx_insn_decoder
  import pfx_dec_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] win_base,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_instr,
  output logic          dec_valid,
  output logic [2:0]    dec_class,
  output logic [4:0]    dec_opcode,
  output logic [2:0]    dec_rd,
  output logic [2:0]    dec_ra,
  output logic [2:0]    dec_rb,
  output logic [15:0]   dec_imm,
  output logic          dec_illegal,
  output logic          step_valid,
  input  logic          step_ready,
  output logic [2:0]    step_op,
  output logic [AW-1:0] step_addr,
  output logic          step_last
);

  logic [IW-1:0]    instr_q;
  iclass_e          cls;
  logic [SLOTW-1:0] rd, ra, rb;
  logic             illegal;
  logic [CNTW-1:0]  count;
  step_t            steps [MAX_STEPS];

  pfx_field_dec u_fields (
    .instr   (instr_q),
    .cls     (cls),
    .opcode  (dec_opcode),
    .rd      (rd),
    .ra      (ra),
    .rb      (rb),
    .imm     (dec_imm),
    .illegal (illegal)
  );

  pfx_step_plan u_plan (
    .instr   (instr_q),
    .cls     (cls),
    .rd      (rd),
    .ra      (ra),
    .rb      (rb),
    .illegal (illegal),
    .count   (count),
    .steps   (steps)
  );

  pfx_step_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_base   (win_base),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_instr   (in_instr),
    .count      (count),
    .steps      (steps),
    .held       (dec_valid),
    .instr_q    (instr_q),
    .step_valid (step_valid),
    .step_ready (step_ready),
    .step_op    (step_op),
    .step_addr  (step_addr),
    .step_last  (step_last)
  );

  assign dec_class   = cls;
  assign dec_rd      = rd;
  assign dec_ra      = ra;
  assign dec_rb      = rb;
  assign dec_illegal = illegal;

endmodule

// File: rtl/pfx_insn_decoder_chk.sv
module pfx_insn_decoder_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] win_base,
  input logic          dec_valid,
  input logic [2:0]    dec_class,
  input logic [4:0]    dec_opcode,
  input logic          dec_illegal,
  input logic          step_valid,
  input logic          step_ready,
  input logic [2:0]    step_op,
  input logic [AW-1:0] step_addr,
  input logic          step_last
);

  // R12
  no_step_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !step_valid);

  // R11
  stalled_step_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ready |=> step_valid && $stable(step_op) &&
                                  $stable(step_last) && $stable(dec_opcode));

  // R10
  illegal_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_illegal |-> !step_valid);

  // R8
  ctrl_single_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && dec_class == 3'd4 |-> step_op == 3'd7 && step_last);

  // R6
  store_no_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && dec_class == 3'd2 && dec_opcode[0] |-> step_op != 3'd2);

  // R9
  reg_step_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && (step_op == 3'd1 || step_op == 3'd2) |->
      step_addr[AW-1:3] == win_base[AW-1:3]);

  // R9
  other_step_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_op != 3'd1 && step_op != 3'd2 |-> step_addr == '0);

endmodule

bind pfx_insn_decoder pfx_insn_decoder_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_base    (win_base),
  .dec_valid   (dec_valid),
  .dec_class   (dec_class),
  .dec_opcode  (dec_opcode),
  .dec_illegal (dec_illegal),
  .step_valid  (step_valid),
  .step_ready  (step_ready),
  .step_op     (step_op),
  .step_addr   (step_addr),
  .step_last   (step_last)
);

// File: tb/tb_pfx_insn_decoder.sv
module tb_pfx_insn_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int RUN_CYCLES = 8000;
  localparam int WDOG       = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] win_base;
  logic          in_valid;
  logic          in_ready;
  logic [15:0]   in_instr;
  logic          dec_valid;
  logic [2:0]    dec_class;
  logic [4:0]    dec_opcode;
  logic [2:0]    dec_rd, dec_ra, dec_rb;
  logic [15:0]   dec_imm;
  logic          dec_illegal;
  logic          step_valid;
  logic          step_ready;
  logic [2:0]    step_op;
  logic [AW-1:0] step_addr;
  logic          step_last;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_insn_decoder #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .win_base(win_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .dec_valid(dec_valid), .dec_class(dec_class), .dec_opcode(dec_opcode),
    .dec_rd(dec_rd), .dec_ra(dec_ra), .dec_rb(dec_rb), .dec_imm(dec_imm),
    .dec_illegal(dec_illegal), .step_valid(step_valid), .step_ready(step_ready),
    .step_op(step_op), .step_addr(step_addr), .step_last(step_last)
  );

  // Reference model state
  bit          m_busy = 0;
  logic [15:0] m_instr = '0;
  int          exp_q[$];   // op*8 + slot

  logic [15:0] directed[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int cls_of(input logic [15:0] w);
    casez (w[15:11])
      5'b1????: return 4;
      5'b01???: return 3;
      5'b001??: return 2;
      5'b0001?: return 1;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [15:0] imm_of(input logic [15:0] w);
    case (cls_of(w))
      4: return {{5{w[10]}}, w[10:0]};
      3: return {{8{w[7]}}, w[7:0]};
      2: return {11'd0, w[4:0]};
      1: return {12'd0, w[4:1]};
      default: return 16'd0;
    endcase
  endfunction

  function automatic bit illegal_of(input logic [15:0] w);
    return (w[15:12] == 4'b0000 && w[1:0] == 2'b11) || (w[15:11] == 5'b10001);
  endfunction

  function automatic string step_tag(input logic [15:0] w);
    case (cls_of(w))
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic push(input int op, input int slot);
    exp_q.push_back(op * 8 + slot);
  endtask

  task automatic build_plan(input logic [15:0] w);
    int d, a, b;
    d = int'(w[10:8]); a = int'(w[7:5]); b = int'(w[4:2]);
    exp_q.delete();
    if (illegal_of(w)) return;
    casez (w[15:11])
      5'b0000?: begin push(1, b); push(1, a); push(2, d); end
      5'b0001?: begin push(1, a); push(2, d); end
      5'b00100: begin push(1, a); push(3, 0); push(2, d); end
      5'b00110: begin push(1, a); push(5, 0); push(2, d); end
      5'b00101: begin push(1, a); push(1, d); push(4, 0); end
      5'b00111: begin push(1, a); push(1, d); push(6, 0); end
      5'b0100?: begin push(1, d); push(2, d); end
      5'b0101?: begin push(2, d); end
      5'b01100: begin push(3, 0); push(2, d); end
      5'b01101: begin push(1, d); push(4, 0); end
      5'b01110: begin push(2, d); push(7, 0); end
      5'b01111: begin push(1, d); push(7, 0); end
      default:  begin push(7, 0); end
    endcase
  endtask

  task automatic compare();
    int op, slot;
    bit exp_done;
    logic [AW-1:0] exp_addr;
    vectors++;
    exp_done = m_busy && (exp_q.size() == 0 || (step_ready && exp_q.size() == 1));
    chk(in_ready == (!m_busy || exp_done), "R11", "in_ready", in_ready, !m_busy || exp_done);
    chk(dec_valid == m_busy, "R11", "dec_valid", dec_valid, m_busy);
    if (!m_busy) begin
      chk(step_valid == 1'b0, "R11", "step_valid idle", step_valid, 0);
      return;
    end
    chk(dec_class == 3'(cls_of(m_instr)), "R1", "dec_class", dec_class, cls_of(m_instr));
    chk(dec_opcode == m_instr[15:11], "R1", "dec_opcode", dec_opcode, m_instr[15:11]);
    chk(dec_rd == m_instr[10:8], "R2", "dec_rd", dec_rd, m_instr[10:8]);
    chk(dec_ra == m_instr[7:5], "R2", "dec_ra", dec_ra, m_instr[7:5]);
    chk(dec_rb == m_instr[4:2], "R2", "dec_rb", dec_rb, m_instr[4:2]);
    chk(dec_imm == imm_of(m_instr), "R3", "dec_imm", dec_imm, imm_of(m_instr));
    chk(dec_illegal == illegal_of(m_instr), "R10", "dec_illegal", dec_illegal,
        illegal_of(m_instr));
    chk(step_valid == (exp_q.size() > 0), illegal_of(m_instr) ? "R10" : step_tag(m_instr),
        "step_valid", step_valid, exp_q.size() > 0);
    if (exp_q.size() > 0 && step_valid) begin
      op   = exp_q[0] / 8;
      slot = exp_q[0] % 8;
      exp_addr = (op == 1 || op == 2) ? {win_base[AW-1:3], 3'(slot)} : '0;
      chk(step_op == 3'(op), step_tag(m_instr), "step_op", step_op, op);
      chk(step_addr == exp_addr, "R9", "step_addr", step_addr, exp_addr);
      chk(step_last == (exp_q.size() == 1), "R11", "step_last", step_last,
          exp_q.size() == 1);
    end
  endtask

  task automatic advance_model(output bit took);
    bit done_now;
    done_now = m_busy && (exp_q.size() == 0 || (step_ready && exp_q.size() == 1));
    took = in_valid && (!m_busy || done_now);
    if (took) begin
      m_busy  = 1;
      m_instr = in_instr;
      build_plan(in_instr);
    end else if (done_now) begin
      m_busy = 0;
      exp_q.delete();
    end else if (m_busy && exp_q.size() > 0 && step_ready) begin
      void'(exp_q.pop_front());
    end
  endtask

  function automatic logic [15:0] mk(input logic [4:0] opc, input logic [10:0] low);
    return {opc, low};
  endfunction

  initial begin
    bit took;
    int didx;
    took = 0;
    didx = 0;
    directed.push_back(mk(5'b00000, {3'd3, 3'd1, 3'd2, 2'b00}));
    directed.push_back(mk(5'b00000, {3'd5, 3'd6, 3'd7, 2'b11}));  // R10 illegal ALU
    directed.push_back(mk(5'b00001, {3'd7, 3'd0, 3'd4, 2'b10}));
    directed.push_back(mk(5'b00001, {3'd2, 3'd2, 3'd2, 2'b11}));  // R10 illegal logic
    directed.push_back(mk(5'b00010, {3'd1, 3'd4, 4'hF, 1'b1}));
    directed.push_back(mk(5'b00011, {3'd6, 3'd3, 4'h8, 1'b0}));
    directed.push_back(mk(5'b00100, {3'd2, 3'd5, 5'h1F}));
    directed.push_back(mk(5'b00101, {3'd4, 3'd1, 5'h10}));
    directed.push_back(mk(5'b00110, {3'd0, 3'd7, 5'h03}));
    directed.push_back(mk(5'b00111, {3'd3, 3'd2, 5'h00}));
    directed.push_back(mk(5'b01000, {3'd5, 8'h80}));
    directed.push_back(mk(5'b01001, {3'd1, 8'h7F}));
    directed.push_back(mk(5'b01010, {3'd2, 8'hFF}));
    directed.push_back(mk(5'b01011, {3'd3, 8'h01}));
    directed.push_back(mk(5'b01100, {3'd4, 8'hC0}));
    directed.push_back(mk(5'b01101, {3'd6, 8'h40}));
    directed.push_back(mk(5'b01110, {3'd7, 8'hFE}));
    directed.push_back(mk(5'b01111, {3'd0, 8'h02}));
    directed.push_back(mk(5'b10000, 11'h400));
    directed.push_back(mk(5'b10001, 11'h123));                    // R10 illegal jump
    directed.push_back(mk(5'b10011, 11'h3FF));
    directed.push_back(mk(5'b11111, 11'h7FF));
    directed.push_back(mk(5'b10110, 11'h000));

    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; step_ready = 1'b0;
    win_base = 16'h1238;
    repeat (3) begin
      @(negedge clk);
      vectors++;
      // R12 reset state
      chk(in_ready == 1'b1, "R12", "in_ready in reset", in_ready, 1);
      chk(dec_valid == 1'b0, "R12", "dec_valid in reset", dec_valid, 0);
      chk(step_valid == 1'b0, "R12", "step_valid in reset", step_valid, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    chk(dec_valid == 1'b0 && step_valid == 1'b0, "R12", "idle after reset",
        {dec_valid, step_valid}, 0);

    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      if (cyc % 37 == 0) win_base = 16'($urandom);
      step_ready = ($urandom % 4) != 0;
      if (!in_valid || took) begin
        in_valid = ($urandom % 3) != 0;
        if (didx < directed.size()) in_instr = directed[didx];
        else                        in_instr = 16'($urandom);
      end
      #1;
      compare();
      advance_model(took);
      if (took && didx < directed.size()) didx++;
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule